// File: doc/BRIEF.md
# AES-128 Encryption Datapath with Selectable Round Staging

This block encrypts one 128-bit plaintext block under a 128-bit key using the AES-128 cipher. It is iterative: a single round datapath is reused for all ten rounds. The round keys are derived on the fly from the key supplied with the plaintext, so nothing is stored between blocks. The caller presents a block and a key with `in_valid`. The block accepts them whenever `in_ready` is high. It later pulses `out_valid` for one cycle with the ciphertext on `out_cipher`.

The parameter `STAGES` (1, 2 or 3) sets how many register stages each round uses, and the key-schedule step is split to match. One stage gives the lowest latency. Two or three stages shorten the longest combinational path at the cost of more cycles per block. The number of rounds stays the same.

Byte order: byte index 0 is bits [127:120] of a 128-bit word, and byte index i is bits [127-8i -: 8]. State element (row r, column c) is byte index 4c + r of the plaintext. The ciphertext is laid out the same way.

Top module: `aes128_enc`

## Requirements
- R1: `out_cipher` equals the AES-128 encryption of the accepted plaintext under the accepted key, using the byte order above. For example, key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff give 69c4e0d86a7b0430d8cdb78070b4c55a.
- R2: The raw key is XORed into the state before round 1. Rounds 1 to 9 apply byte substitution, row rotation (row r rotated left by r bytes), column mixing with coefficients 02h/03h and round-key addition. Round 10 omits column mixing.
- R3: The key schedule uses round constants 01, 02, 04, 08, 10, 20, 40, 80, 1B and 36 (hex) for rounds 1 to 10.
- R4: With S = `STAGES`, `out_valid` is high exactly 10·S + 1 cycles after the cycle in which the input was accepted.
- R5: `out_valid` is a single-cycle pulse, and `out_cipher` carries the result in that cycle.
- R6: `in_ready` falls in the cycle after an accepted input and stays low until the cycle in which `out_valid` is high. An `in_valid` offered while `in_ready` is low is ignored and does not alter the result in flight.
- R7: A new input may be accepted in the same cycle as `out_valid`. Its result follows 10·S + 1 cycles later.
- R8: After reset, `in_ready` is 1 and `out_valid` is 0.
- R9: STAGES = 1, 2 and 3 produce identical ciphertexts for the same inputs. The working round key changes only in the last stage of a round.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Plaintext and key are offered |
| in_ready | output | 1 | Block is idle and will accept an offer |
| in_plain | input | 128 | Plaintext block |
| in_key | input | 128 | Cipher key |
| out_valid | output | 1 | One-cycle pulse, ciphertext valid |
| out_cipher | output | 128 | Ciphertext |

## Verification
The assertions check the handshake timing on every cycle:
- the exact latency of 10·S + 1, counted by a checker counter;
- the single-cycle width of `out_valid`;
- `in_ready` dropping after an accept;
- the last round constant being 36h;
- the working key holding steady in the inner stages of a round.

Whether the ciphertext is correct can only be shown by the bench. It compares three instances, one for each staging choice, against a separately written software cipher and two known-answer vectors. Two properties also need specific bench scenarios: that junk offers made while the block is busy leave the result unchanged, and that a back-to-back accept in the output cycle works.

// File: rtl/aes128_pkg.sv
package aes128_pkg;

    typedef logic [127:0] blk_t;
    typedef logic [31:0]  word_t;
    typedef logic [7:0]   byte_t;

    localparam int NUM_ROUNDS = 10;
    localparam byte_t RCON_FIRST = 8'h01;

    // multiply by x modulo x^8+x^4+x^3+x+1
    function automatic byte_t gf_xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t aa;
        acc = 8'h00;
        aa  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = gf_xtime(aa);
        end
        return acc;
    endfunction

    // substitution: multiplicative inverse (a^254) then affine map
    function automatic byte_t sbox_calc(input byte_t x);
        byte_t x2, x3, x6, x12, x15, x30, x60, x120, x240, x252, inv;
        x2   = gf_mul(x, x);
        x3   = gf_mul(x2, x);
        x6   = gf_mul(x3, x3);
        x12  = gf_mul(x6, x6);
        x15  = gf_mul(x12, x3);
        x30  = gf_mul(x15, x15);
        x60  = gf_mul(x30, x30);
        x120 = gf_mul(x60, x60);
        x240 = gf_mul(x120, x120);
        x252 = gf_mul(x240, x12);
        inv  = gf_mul(x252, x2);
        return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    endfunction

    function automatic byte_t get_byte(input blk_t b, input int idx);
        return b[127 - 8*idx -: 8];
    endfunction

    // row r rotated left by r: element (r,c) takes (r,(c+r)%4)
    function automatic blk_t shift_rows(input blk_t s);
        blk_t o;
        o = '0;
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                o[127 - 8*(4*c + r) -: 8] = get_byte(s, 4*((c + r) % 4) + r);
            end
        end
        return o;
    endfunction

    function automatic word_t mix_column(input word_t col);
        byte_t a0, a1, a2, a3;
        a0 = col[31:24];
        a1 = col[23:16];
        a2 = col[15:8];
        a3 = col[7:0];
        return {gf_xtime(a0) ^ gf_xtime(a1) ^ a1 ^ a2 ^ a3,
                a0 ^ gf_xtime(a1) ^ gf_xtime(a2) ^ a2 ^ a3,
                a0 ^ a1 ^ gf_xtime(a2) ^ gf_xtime(a3) ^ a3,
                gf_xtime(a0) ^ a0 ^ a1 ^ a2 ^ gf_xtime(a3)};
    endfunction

    function automatic blk_t mix_columns(input blk_t s);
        blk_t o;
        o = '0;
        for (int c = 0; c < 4; c++) begin
            o[127 - 32*c -: 32] = mix_column(s[127 - 32*c -: 32]);
        end
        return o;
    endfunction

endpackage

// File: rtl/aes128_sbox.sv
module aes128_sbox
    import aes128_pkg::*;
(
    input  logic [7:0] sub_in,
    output logic [7:0] sub_out
);
    always_comb begin
        sub_out = sbox_calc(sub_in);
    end
endmodule

// File: rtl/aes128_key_step.sv
module aes128_key_step
    import aes128_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic [127:0] cur_key,
    input  logic [7:0]   rcon,
    input  logic [31:0]  mix_word_reg,
    output logic [31:0]  mix_word,
    output logic [127:0] next_key
);
    localparam int NBYTE = 4;

    logic [31:0] last_w;
    logic [31:0] rot_w;
    logic [31:0] sub_w;
    logic [31:0] use_w;
    logic [31:0] n0, n1, n2, n3;

    assign last_w = cur_key[31:0];
    assign rot_w  = {last_w[23:0], last_w[31:24]};

    for (genvar g = 0; g < NBYTE; g++) begin : g_ksub
        aes128_sbox u_sbox (
            .sub_in  (rot_w[8*g +: 8]),
            .sub_out (sub_w[8*g +: 8])
        );
    end

    always_comb begin
        mix_word = sub_w ^ {rcon, 24'h0};
    end

    // single-stage rounds use the word directly, staged rounds use the registered copy
    if (STAGES == 1) begin : g_direct
        assign use_w = mix_word;
        logic unused_reg;
        assign unused_reg = ^mix_word_reg;
    end else begin : g_staged
        assign use_w = mix_word_reg;
    end

    always_comb begin
        n0 = cur_key[127:96] ^ use_w;
        n1 = cur_key[95:64]  ^ n0;
        n2 = cur_key[63:32]  ^ n1;
        n3 = cur_key[31:0]   ^ n2;
        next_key = {n0, n1, n2, n3};
    end
endmodule

// File: rtl/aes128_round_path.sv
module aes128_round_path
    import aes128_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic [127:0] state_in,
    input  logic [1:0]   phase,
    input  logic         last_round,
    input  logic [127:0] round_key,
    output logic [127:0] state_out
);
    localparam int NBYTES = 16;
    localparam logic [1:0] SUB_PH = 2'd0;
    localparam logic [1:0] SR_PH  = (STAGES == 3) ? 2'd1 : 2'd0;
    localparam logic [1:0] MIX_PH = (STAGES == 1) ? 2'd0 : 2'd1;
    localparam logic [1:0] ADD_PH = 2'(STAGES - 1);

    logic [127:0] subbed;
    logic [127:0] a_d, b_d, c_d;

    for (genvar g = 0; g < NBYTES; g++) begin : g_sub
        aes128_sbox u_sbox (
            .sub_in  (state_in[127 - 8*g -: 8]),
            .sub_out (subbed[127 - 8*g -: 8])
        );
    end

    always_comb begin
        a_d = (phase == SUB_PH) ? subbed : state_in;
        b_d = (phase == SR_PH) ? shift_rows(a_d) : a_d;
        c_d = (phase == MIX_PH && !last_round) ? mix_columns(b_d) : b_d;
        state_out = (phase == ADD_PH) ? (c_d ^ round_key) : c_d;
    end
endmodule

// File: rtl/aes128_enc.sv
module aes128_enc
    import aes128_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [127:0] in_plain,
    input  logic [127:0] in_key,
    output logic         out_valid,
    output logic [127:0] out_cipher
);
    localparam logic [1:0] LAST_PH = 2'(STAGES - 1);
    localparam logic [3:0] FINAL_RND = 4'(NUM_ROUNDS);
    localparam int LAT = NUM_ROUNDS * STAGES + 1;
    localparam int CW  = $clog2(LAT + 1);

    typedef struct packed {
        logic        busy;
        logic        done;
        logic [3:0]  round;
        logic [1:0]  phase;
        logic [7:0]  rcon;
        logic [31:0] kword;
        blk_t        state;
        blk_t        key;
    } core_t;

    core_t core_d, core_q;

    logic [31:0]  mix_word;
    logic [127:0] next_key;
    logic [127:0] path_out;

    aes128_key_step #(.STAGES(STAGES)) u_key_step (
        .cur_key      (core_q.key),
        .rcon         (core_q.rcon),
        .mix_word_reg (core_q.kword),
        .mix_word     (mix_word),
        .next_key     (next_key)
    );

    aes128_round_path #(.STAGES(STAGES)) u_round_path (
        .state_in   (core_q.state),
        .phase      (core_q.phase),
        .last_round (core_q.round == FINAL_RND),
        .round_key  (next_key),
        .state_out  (path_out)
    );

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        if (!core_q.busy) begin
            if (in_valid) begin
                core_d.busy  = 1'b1;
                core_d.state = in_plain ^ in_key;
                core_d.key   = in_key;
                core_d.round = 4'd1;
                core_d.phase = 2'd0;
                core_d.rcon  = RCON_FIRST;
            end
        end else begin
            core_d.state = path_out;
            if (core_q.phase == 2'd0) core_d.kword = mix_word;
            if (core_q.phase == LAST_PH) begin
                core_d.key   = next_key;
                core_d.phase = 2'd0;
                core_d.rcon  = gf_xtime(core_q.rcon);
                if (core_q.round == FINAL_RND) begin
                    core_d.busy = 1'b0;
                    core_d.done = 1'b1;
                end else begin
                    core_d.round = core_q.round + 4'd1;
                end
            end else begin
                core_d.phase = core_q.phase + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign in_ready   = !core_q.busy;
    assign out_valid  = core_q.done;
    assign out_cipher = core_q.state;

    // latency counter used only by the checks below
    logic [CW-1:0] lat_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                     lat_cnt_q <= '0;
        else if (in_valid && in_ready)  lat_cnt_q <= CW'(1);
        else if (core_q.busy)           lat_cnt_q <= lat_cnt_q + CW'(1);
    end

    // R4
    latency_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> lat_cnt_q == CW'(LAT));
    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R6
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    // R6
    ready_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);
    // R3
    last_rcon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.busy && core_q.round == FINAL_RND) |-> core_q.rcon == 8'h36);
    // R9
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.busy && core_q.phase != LAST_PH) |=> $stable(core_q.key));
endmodule

// File: tb/aes128_enc_bench.sv
module aes128_enc_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n;
    logic [2:0]   iv;
    logic [127:0] pt, key;
    logic [2:0]   rdy, ov;
    logic [127:0] ct [3];

    int errors = 0;
    int checks = 0;
    bit summary_done = 1'b0;
    logic [7:0] sb [256];

    aes128_enc #(.STAGES(1)) u_aes128_enc_s1 (
        .clk(clk), .rst_n(rst_n), .in_valid(iv[0]), .in_ready(rdy[0]),
        .in_plain(pt), .in_key(key), .out_valid(ov[0]), .out_cipher(ct[0]));
    aes128_enc #(.STAGES(2)) u_aes128_enc (
        .clk(clk), .rst_n(rst_n), .in_valid(iv[1]), .in_ready(rdy[1]),
        .in_plain(pt), .in_key(key), .out_valid(ov[1]), .out_cipher(ct[1]));
    aes128_enc #(.STAGES(3)) u_aes128_enc_s3 (
        .clk(clk), .rst_n(rst_n), .in_valid(iv[2]), .in_ready(rdy[2]),
        .in_plain(pt), .in_key(key), .out_valid(ov[2]), .out_cipher(ct[2]));

    function automatic logic [7:0] xt(input logic [7:0] a);
        return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // table built by walking generator 3 and its inverse
    task automatic build_sbox();
        logic [7:0] p, q, x;
        p = 8'h01; q = 8'h01;
        do begin
            p = p ^ xt(p);
            q = q ^ (q << 1);
            q = q ^ (q << 2);
            q = q ^ (q << 4);
            if (q[7]) q = q ^ 8'h09;
            x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
            sb[p] = x ^ 8'h63;
        end while (p != 8'h01);
        sb[0] = 8'h63;
    endtask

    function automatic logic [127:0] ref_enc(input logic [127:0] p_in, input logic [127:0] k_in);
        logic [7:0] s [16];
        logic [7:0] t [16];
        logic [7:0] k [16];
        logic [7:0] rc, a0, a1, a2, a3;
        logic [127:0] o;
        for (int i = 0; i < 16; i++) begin
            k[i] = k_in[127 - 8*i -: 8];
            s[i] = p_in[127 - 8*i -: 8] ^ k[i];
        end
        rc = 8'h01;
        for (int r = 1; r <= 10; r++) begin
            for (int i = 0; i < 16; i++) s[i] = sb[s[i]];
            for (int c = 0; c < 4; c++)
                for (int w = 0; w < 4; w++) t[4*c + w] = s[4*((c + w) % 4) + w];
            for (int c = 0; c < 4; c++) begin
                a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
                if (r < 10) begin
                    s[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
                    s[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
                    s[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
                    s[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
                end else begin
                    s[4*c] = a0; s[4*c+1] = a1; s[4*c+2] = a2; s[4*c+3] = a3;
                end
            end
            k[0] = k[0] ^ sb[k[13]] ^ rc;
            k[1] = k[1] ^ sb[k[14]];
            k[2] = k[2] ^ sb[k[15]];
            k[3] = k[3] ^ sb[k[12]];
            for (int i = 4; i < 16; i++) k[i] = k[i] ^ k[i-4];
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ k[i];
            rc = xt(rc);
        end
        for (int i = 0; i < 16; i++) o[127 - 8*i -: 8] = s[i];
        return o;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // all three instances start together; noise offers junk while busy (R6)
    task automatic run_block(input logic [127:0] p_i, input logic [127:0] k_i,
                             input bit noise, input bit use_kat, input logic [127:0] kat);
        logic [127:0] exp;
        exp = use_kat ? kat : ref_enc(p_i, k_i);
        @(negedge clk);
        pt = p_i; key = k_i; iv = 3'b111;
        for (int k = 1; k <= 31; k++) begin
            @(negedge clk);
            for (int i = 0; i < 3; i++) begin
                int lat;
                lat = 10 * (i + 1) + 1;
                chk(ov[i] == (k == lat), "R4 R5 out_valid timing", {127'd0, ov[i]}, {127'd0, k == lat});
                chk(rdy[i] == (k >= lat), "R6 in_ready while busy", {127'd0, rdy[i]}, {127'd0, k >= lat});
                if (k == lat)
                    chk(ct[i] == exp, "R1 R2 R3 R9 ciphertext", ct[i], exp);
                iv[i] = noise && (k < lat);
            end
            if (noise) begin pt = rnd128(); key = rnd128(); end
        end
        iv = 3'b000;
    endtask

    // R7: new block accepted in the output cycle of the previous one (two-stage instance)
    task automatic back_to_back(input logic [127:0] pa, input logic [127:0] ka,
                                input logic [127:0] pb, input logic [127:0] kb);
        logic [127:0] ea, eb;
        ea = ref_enc(pa, ka);
        eb = ref_enc(pb, kb);
        @(negedge clk);
        pt = pa; key = ka; iv = 3'b010;
        for (int k = 1; k <= 21; k++) begin
            @(negedge clk);
            iv = 3'b000;
            if (k == 21) begin
                chk(ov[1] == 1'b1, "R7 first pulse", {127'd0, ov[1]}, 128'd1);
                chk(ct[1] == ea, "R7 first result", ct[1], ea);
                pt = pb; key = kb; iv = 3'b010;
            end
        end
        for (int k = 1; k <= 21; k++) begin
            @(negedge clk);
            iv = 3'b000;
            chk(ov[1] == (k == 21), "R7 second pulse timing", {127'd0, ov[1]}, {127'd0, k == 21});
            if (k == 21) chk(ct[1] == eb, "R7 second result", ct[1], eb);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!summary_done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            summary_done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd5813));
        build_sbox();
        rst_n = 1'b0; iv = 3'b000; pt = '0; key = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdy == 3'b111, "R8 in_ready after reset", {125'd0, rdy}, 128'd7);
        chk(ov == 3'b000, "R8 out_valid after reset", {125'd0, ov}, 128'd0);

        run_block(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
                  1'b0, 1'b1, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        run_block(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c,
                  1'b1, 1'b1, 128'h3925841d02dc09fbdc118597196a0b32);
        run_block('0, '0, 1'b0, 1'b0, '0);
        run_block('1, '1, 1'b1, 1'b0, '0);
        for (int n = 0; n < 16; n++) run_block(rnd128(), rnd128(), n[0], 1'b0, '0);
        back_to_back(rnd128(), rnd128(), rnd128(), rnd128());

        if (!summary_done) begin
            summary_done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule